// File: doc/BRIEF.md
# Dual-Lane Serial Converter Frame Writer

This block sends one 16-bit frame to each of two write-only serial digital-to-analog converters in a single transfer. Both converters sit on one active-low chip select and one serial clock, while each has its own data line, so the two frames shift out side by side, bit for bit, in the same clock pulses. Every frame is a control byte followed by a data byte. The control byte picks one of the converter's two output channels and how it updates, so the pair of converters offers four outputs in total.

The caller presents a control byte and a data byte for each lane and pulses a start strobe. The block drops chip select, runs exactly sixteen serial clock pulses and releases chip select again. It then flags completion with a one-cycle pulse. To write only one converter, the caller places on the other lane a control byte that leaves that device's outputs as they are. The block sends both lanes verbatim and does not interpret the bytes. The serial clock half-period, in system clock cycles, is a parameter.

Top module: `dual_lane_dac_writer`

## Requirements
- R1: Out of reset and while idle, cs_n_o is 1, sclk_o is 1 (the clock idles high), busy_o is 0 and done_o is 0.
- R2: A start_i seen high at a rising clk_i edge while busy_o is 0 latches both frames. From that edge on, cs_n_o is 0 and busy_o is 1, and sclk_o stays high for HALF_DIV more cycles before its first falling edge.
- R3: Every transfer produces exactly 16 rising edges of sclk_o while cs_n_o is 0.
- R4: Each lane's frame is {control[7:0], data[7:0]}, sent most significant bit first. The control byte's bit 7 is sampled at the first rising edge of sclk_o and the data byte's bit 0 at the sixteenth. A data line changes only when sclk_o falls, or when chip select asserts, and is stable across each rising edge.
- R5: Lane A (mosi_a_o) carries the frame built from ctrl_a_i and data_a_i, and lane B (mosi_b_o) carries the frame built from ctrl_b_i and data_b_i. The two lanes shift in the same clock pulses and do not affect each other.
- R6: cs_n_o returns to 1 exactly HALF_DIV cycles after the sixteenth rising edge of sclk_o, with sclk_o high. A whole transfer therefore holds cs_n_o low for 33*HALF_DIV cycles.
- R7: A start_i that arrives while busy_o is 1 is ignored. The frame in progress is not restarted or altered, and no extra frame follows.
- R8: done_o is 1 for exactly one cycle: the first cycle in which cs_n_o is high again. busy_o is 0 in that same cycle, and a start in that cycle is accepted.
- R9: Every high and low phase of sclk_o within a transfer lasts exactly HALF_DIV clk_i cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one dual-lane transfer |
| ctrl_a_i | input | 8 | Control byte for lane A |
| data_a_i | input | 8 | Data byte for lane A |
| ctrl_b_i | input | 8 | Control byte for lane B |
| data_b_i | input | 8 | Data byte for lane B |
| cs_n_o | output | 1 | Shared chip select, active low |
| sclk_o | output | 1 | Shared serial clock, idles high |
| mosi_a_o | output | 1 | Serial data to converter A |
| mosi_b_o | output | 1 | Serial data to converter B |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at chip select release |

## Verification
The hardest case to reach from the ports is a start strobe that lands at the edges of a transfer. One such case is a strobe in the middle of a frame, which must be dropped. The other is a strobe in the very cycle done_o is high, which must be taken at once. The bench raises start_i partway through a frame with other bytes on both lanes. It then checks that chip select stays low, that only the first frame's bits arrive and that no extra frame appears. For the second case, it watches for done_o and drives the next start in that same sampling slot, so the two transfers run back to back.

// File: rtl/dual_lane_dac_pkg.sv
package dual_lane_dac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH
  } seq_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import dual_lane_dac_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic load_o,
  output logic shift_o,
  output logic cs_n_o,
  output logic sclk_o,
  output logic busy_o,
  output logic done_o
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic             last_rise;

  assign last_rise = (bit_q == LAST_BIT);
  assign run_o     = (state_q != ST_IDLE);
  assign busy_o    = run_o;
  assign load_o    = (state_q == ST_IDLE) && start_i;
  // no shift on the first falling edge: bit 15 is already on the line
  assign shift_o   = (state_q == ST_HIGH) && tick_i && !last_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            cs_n_o  <= 1'b0;
            bit_q   <= '0;
          end
        end
        ST_LEAD: begin
          if (tick_i) begin
            sclk_o  <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            sclk_o  <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            if (last_rise) begin
              cs_n_o  <= 1'b1;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              bit_q   <= bit_q + 1'b1;
              sclk_o  <= 1'b0;
              state_q <= ST_LOW;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_lane_shift.sv
module spi_lane_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               mosi_o
);
  logic [FRAME_W-1:0] sr_q;

  assign mosi_o = sr_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= frame_i;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end
endmodule

// File: rtl/dual_lane_dac_writer.sv
module dual_lane_dac_writer #(
  parameter int HALF_DIV = 4,
  parameter int CTRL_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_a_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [CTRL_W-1:0] ctrl_b_i,
  input  logic [DATA_W-1:0] data_b_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              mosi_a_o,
  output logic              mosi_b_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = CTRL_W + DATA_W;
  localparam int N_LANES = 2;

  logic run, tick, load, shift;
  logic [N_LANES-1:0][FRAME_W-1:0] frame;
  logic [N_LANES-1:0]              mosi;

  assign frame[0] = {ctrl_a_i, data_a_i};
  assign frame[1] = {ctrl_b_i, data_b_i};
  assign mosi_a_o = mosi[0];
  assign mosi_b_o = mosi[1];

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .run_o   (run),
    .load_o  (load),
    .shift_o (shift),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    spi_lane_shift #(.FRAME_W(FRAME_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .frame_i (frame[g]),
      .mosi_o  (mosi[g])
    );
  end
endmodule

// File: rtl/dual_lane_dac_checker.sv
module dual_lane_dac_checker #(
  parameter int HALF_DIV = 4,
  parameter int FRAME_W  = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_a_o,
  input logic mosi_b_o,
  input logic busy_o,
  input logic done_o
);
  logic        sclk_q, cs_q;
  logic [31:0] gap_q;
  logic [31:0] rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      gap_q  <= '0;
      rise_q <= '0;
    end else begin
      sclk_q <= sclk_o;
      cs_q   <= cs_n_o;
      if ((sclk_o != sclk_q) || (cs_n_o != cs_q)) gap_q <= '0;
      else                                        gap_q <= gap_q + 1;
      if (cs_n_o)                  rise_q <= '0;
      else if (sclk_o && !sclk_q)  rise_q <= rise_q + 1;
    end
  end

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sclk_o);

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!cs_n_o && busy_o && sclk_o));

  p_rise_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (rise_q == 32'(FRAME_W)));

  p_mosi_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && sclk_o && $past(sclk_o) && !$past(cs_n_o))
      |-> ($stable(mosi_a_o) && $stable(mosi_b_o)));

  p_release_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (sclk_o && gap_q == 32'(HALF_DIV - 1)));

  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !busy_o && $past(!cs_n_o)));

  p_half_period_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !$stable(sclk_o)) |-> (gap_q == 32'(HALF_DIV - 1)));
endmodule

bind dual_lane_dac_writer dual_lane_dac_checker #(
  .HALF_DIV (HALF_DIV),
  .FRAME_W  (CTRL_W + DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .cs_n_o   (cs_n_o),
  .sclk_o   (sclk_o),
  .mosi_a_o (mosi_a_o),
  .mosi_b_o (mosi_b_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/dual_lane_dac_writer_tb.sv
module dual_lane_dac_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int FRAME_LEN  = 33 * DIV;
  localparam int WD_CYCLES  = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] ctrl_a_i = '0, data_a_i = '0, ctrl_b_i = '0, data_b_i = '0;
  logic       cs_n_o, sclk_o, mosi_a_o, mosi_b_o, busy_o, done_o;

  int n_checks = 0;
  int n_fails  = 0;
  int n_sent   = 0;
  int n_seen   = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dual_lane_dac_writer #(.HALF_DIV(DIV)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ctrl_a_i (ctrl_a_i),
    .data_a_i (data_a_i),
    .ctrl_b_i (ctrl_b_i),
    .data_b_i (data_b_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .mosi_a_o (mosi_a_o),
    .mosi_b_o (mosi_b_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  task automatic check(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // driver: called at a falling edge of clk_i
  task automatic send(input [7:0] ca, input [7:0] da, input [7:0] cb, input [7:0] db);
    ctrl_a_i = ca; data_a_i = da; ctrl_b_i = cb; data_b_i = db;
    start_i  = 1'b1;
    exp_q.push_back({ca, da, cb, db});
    n_sent++;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!cs_n_o && busy_o && sclk_o, "R2 cs low busy high after start",
          {29'd0, cs_n_o, busy_o, sclk_o}, 32'b011);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  logic        prev_cs = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0;
  logic [15:0] cap_a, cap_b;
  int          rises, len;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_cs && !cs_n_o) begin
        cap_a = '0; cap_b = '0; rises = 0; len = 0;
      end
      if (!cs_n_o) begin
        len++;
        if (sclk_o && !prev_sclk) begin
          cap_a = {cap_a[14:0], mosi_a_o};
          cap_b = {cap_b[14:0], mosi_b_o};
          rises++;
        end
      end
      if (!prev_cs && cs_n_o) begin
        logic [31:0] exp_w;
        n_seen++;
        check(rises == 16, "R3 sixteen rising edges", 32'(rises), 32'd16);
        check(len == FRAME_LEN, "R6/R9 chip select low time", 32'(len), 32'(FRAME_LEN));
        check(sclk_o == 1'b1, "R6 clock high at release", {31'd0, sclk_o}, 32'd1);
        check(done_o && !busy_o, "R8 done with release, busy low",
              {30'd0, done_o, busy_o}, 32'b10);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected extra frame", {cap_a, cap_b}, 32'd0);
        end else begin
          exp_w = exp_q.pop_front();
          check(cap_a == exp_w[31:16], "R4/R5 lane A frame msb first", {16'd0, cap_a}, {16'd0, exp_w[31:16]});
          check(cap_b == exp_w[15:0],  "R4/R5 lane B frame msb first", {16'd0, cap_b}, {16'd0, exp_w[15:0]});
        end
      end
      if (prev_done) check(!done_o, "R8 done lasts one cycle", {31'd0, done_o}, 32'd0);
    end
    prev_cs   = cs_n_o;
    prev_sclk = sclk_o;
    prev_done = done_o;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(cs_n_o && sclk_o && !busy_o && !done_o, "R1 reset state",
          {28'd0, cs_n_o, sclk_o, busy_o, done_o}, 32'b1100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(cs_n_o && sclk_o && !busy_o && !done_o, "R1 idle after reset",
          {28'd0, cs_n_o, sclk_o, busy_o, done_o}, 32'b1100);

    // R5: distinct frames per lane
    send(8'h03, 8'hA5, 8'h10, 8'h3C);
    wait_idle();
    send(8'hFF, 8'hFF, 8'h00, 8'h00);
    wait_idle();
    send(8'h00, 8'h00, 8'hFF, 8'hFF);
    wait_idle();
    // R4: msb and lsb markers
    send(8'h80, 8'h01, 8'h01, 8'h80);
    wait_idle();

    // R7: start during a frame is ignored
    send(8'h24, 8'h5A, 8'h42, 8'hC3);
    repeat (10 * DIV) @(negedge clk_i);
    ctrl_a_i = 8'hEE; data_a_i = 8'h11; ctrl_b_i = 8'h77; data_b_i = 8'h99;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!cs_n_o && busy_o, "R7 frame continues after ignored start",
          {30'd0, cs_n_o, busy_o}, 32'b01);
    wait_idle();
    repeat (5) @(negedge clk_i);
    check(cs_n_o && !busy_o, "R7 no restart after ignored start",
          {30'd0, cs_n_o, busy_o}, 32'b10);

    // R8: start in the done cycle is accepted
    send(8'h31, 8'h6B, 8'h13, 8'hB6);
    while (!done_o) @(negedge clk_i);
    send(8'hC0, 8'h0F, 8'h0C, 8'hF0);
    wait_idle();
    repeat (4) @(negedge clk_i);

    check(exp_q.size() == 0, "R7 all expected frames seen", 32'(exp_q.size()), 32'd0);
    check(n_seen == n_sent, "R7 frame count", 32'(n_seen), 32'(n_sent));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule